// File: doc/BRIEF.md
# Edge-Kicked Watchdog Reset Supervisor

This block watches a processor's service signal and issues a reset when the processor stops servicing it. Service is any level change on the kick input: rising and falling changes count the same. The kick input is asynchronous, so it passes through a two-flop synchronizer. Each change restarts a time-out window. If the window runs out with no change seen, the block asserts a pair of complementary reset outputs for a fixed pulse length. It also drops a latched fault flag, which stays low until the processor produces its next kick.

All timing counts pulses of a clock-enable tick. The window length and the pulse length are parameters, so the same logic serves a 1 ms tick in silicon and very short counts in simulation. A power-good input holds the block in reset, with the fault flag forced high, while the supply is out of range. A disable input parks the window counter so that no time-out can occur. After a synchronous reset, or when power-good returns, the block first runs one full reset pulse and then opens a fresh window.

Top module: `wdt_supervisor`

## Requirements
- R1: A rising or falling change on `kick` is acted on at the third rising clock edge after the input changes, two synchronizer flops plus one edge-compare flop. When acted on outside reset, it restarts the window, so a time-out comes only after a further WIN_TICKS ticks with no change.
- R2: When WIN_TICKS ticks pass in the watch phase with no kick, `rst_out` goes to 1 and `rst_out_n` goes to 0 on the clock edge of the last tick.
- R3: A reset pulse lasts exactly PULSE_TICKS ticks. After it, both reset outputs return inactive and the window starts counting again from zero.
- R4: While `kick` is held constant, reset pulses repeat with a period of WIN_TICKS + PULSE_TICKS ticks.
- R5: `fault_n` goes to 0 on a time-out and stays 0 through the pulse and later time-outs. The next kick change sets it back to 1, even when that change arrives during a reset pulse. A change seen during a pulse does not shorten or lengthen the pulse.
- R6: While `pwr_ok` is 0, `rst_out` is 1, `fault_n` is 1 and no counting takes place. After `pwr_ok` returns to 1, one full PULSE_TICKS pulse runs before the window opens.
- R7: While `wd_off` is 1 no time-out occurs and the window count stays at zero. A reset pulse already in progress still completes. After `wd_off` returns to 0, a full WIN_TICKS window elapses before a time-out.
- R8: Synchronous `rst` at 1 forces the reset phase with `fault_n` at 1. After release, one full PULSE_TICKS pulse precedes the window.
- R9: Counts advance only on clock edges where `tick` is 1. With `tick` held at 0, the reset outputs do not change.
- R10: `rst_out_n` is always the complement of `rst_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Time-base enable; one count per cycle where it is high |
| pwr_ok | input | 1 | Supply in range and not on backup |
| wd_off | input | 1 | Watchdog disable |
| kick | input | 1 | Asynchronous service input; either edge is a kick |
| rst_out | output | 1 | Reset request, active high |
| rst_out_n | output | 1 | Reset request, active low |
| fault_n | output | 1 | Latched watchdog fault, low after a time-out |

## Verification
The main function is tried with three kick patterns. A falling kick placed shortly before expiry shows whether the window restarts from zero or merely pauses. A kick frozen across several periods separates a single time-out from periodic pulsing and shows the fault flag staying latched. A kick landing inside a pulse shows that it clears the fault without altering the pulse length. Disable, power-good loss, a stopped tick and a reset in mid-pulse are each followed by a full window count, which shows that each one parks or restarts the counter instead of letting it run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    // Supervisor phase: holding reset or watching for kicks
    typedef enum logic {
        PH_HOLD  = 1'b0,
        PH_WATCH = 1'b1
    } phase_e;
endpackage

// File: rtl/wdt_kick_edge.sv
module wdt_kick_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic kick_edge
);
    localparam int CHAIN = SYNC_STAGES + 1; // sync flops plus previous-value flop

    logic [CHAIN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN-2:0], kick};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    // any difference between synchronized value and its predecessor is a kick
    assign kick_edge = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int WIN_TICKS   = 1000,
    parameter int PULSE_TICKS = 140
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   pwr_ok,
    input  logic   wd_off,
    input  logic   kick_edge,
    output phase_e phase,
    output logic   fault_n
);
    localparam int CNT_MAX = (WIN_TICKS > PULSE_TICKS) ? WIN_TICKS : PULSE_TICKS;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] WIN_LAST   = CW'(WIN_TICKS - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_TICKS - 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          fault_n;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pwr_ok) begin
            st_d.phase   = PH_HOLD;
            st_d.cnt     = '0;
            st_d.fault_n = 1'b1;
        end else begin
            if (kick_edge) st_d.fault_n = 1'b1;
            unique case (st_q.phase)
                PH_HOLD: begin
                    if (tick) begin
                        if (st_q.cnt == PULSE_LAST) begin
                            st_d.phase = PH_WATCH;
                            st_d.cnt   = '0;
                        end else begin
                            st_d.cnt = st_q.cnt + CW'(1);
                        end
                    end
                end
                PH_WATCH: begin
                    if (kick_edge || wd_off) begin
                        st_d.cnt = '0;
                    end else if (tick) begin
                        if (st_q.cnt == WIN_LAST) begin
                            st_d.phase   = PH_HOLD;
                            st_d.cnt     = '0;
                            st_d.fault_n = 1'b0;
                        end else begin
                            st_d.cnt = st_q.cnt + CW'(1);
                        end
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase   <= PH_HOLD;
            st_q.cnt     <= '0;
            st_q.fault_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase   = st_q.phase;
    assign fault_n = st_q.fault_n;
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
    import wdt_pkg::*;
#(
    parameter int WIN_TICKS   = 1000,
    parameter int PULSE_TICKS = 140,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pwr_ok,
    input  logic wd_off,
    input  logic kick,
    output logic rst_out,
    output logic rst_out_n,
    output logic fault_n
);
    logic   kick_edge;
    phase_e phase;

    wdt_kick_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .kick      (kick),
        .kick_edge (kick_edge)
    );

    wdt_ctrl #(.WIN_TICKS(WIN_TICKS), .PULSE_TICKS(PULSE_TICKS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .pwr_ok    (pwr_ok),
        .wd_off    (wd_off),
        .kick_edge (kick_edge),
        .phase     (phase),
        .fault_n   (fault_n)
    );

    assign rst_out   = (phase == PH_HOLD);
    assign rst_out_n = (phase != PH_HOLD);
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic pwr_ok,
    input logic wd_off,
    input logic kick_edge,
    input logic rst_out,
    input logic rst_out_n,
    input logic fault_n
);
    // R10
    complement_chk: assert property (@(posedge clk) disable iff (rst)
        rst_out_n != rst_out);

    // R6
    pwr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> (rst_out && fault_n));

    // R8
    sys_rst_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
        rst |=> (rst_out && fault_n));

    // R5
    fault_origin_chk: assert property (@(posedge clk) disable iff (rst || !pwr_ok)
        $fell(fault_n) |-> $rose(rst_out));

    // R2
    timeout_flag_chk: assert property (@(posedge clk) disable iff (rst || !pwr_ok)
        $rose(rst_out) |-> !fault_n);

    // R9
    tick_freeze_chk: assert property (@(posedge clk) disable iff (rst || !pwr_ok)
        !tick |=> $stable(rst_out));

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst || !pwr_ok)
        (wd_off && !rst_out) |=> !rst_out);

    // R1
    kick_restart_chk: assert property (@(posedge clk) disable iff (rst || !pwr_ok)
        (kick_edge && !rst_out) |=> !rst_out);
endmodule

bind wdt_supervisor wdt_supervisor_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .pwr_ok    (pwr_ok),
    .wd_off    (wd_off),
    .kick_edge (kick_edge),
    .rst_out   (rst_out),
    .rst_out_n (rst_out_n),
    .fault_n   (fault_n)
);

// File: tb/sim_wdt_supervisor.sv
module sim_wdt_supervisor;
    localparam int WIN   = 10;
    localparam int PULSE = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic pwr_ok = 1'b1;
    logic wd_off = 1'b0;
    logic kick = 1'b1;
    logic rst_out, rst_out_n, fault_n;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        string tag;
        logic  exp_rst;
        logic  exp_flt;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    wdt_supervisor #(.WIN_TICKS(WIN), .PULSE_TICKS(PULSE), .SYNC_STAGES(2)) u0 (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .pwr_ok    (pwr_ok),
        .wd_off    (wd_off),
        .kick      (kick),
        .rst_out   (rst_out),
        .rst_out_n (rst_out_n),
        .fault_n   (fault_n)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic r, input logic f);
        exp_t e;
        e.tag = tag;
        e.exp_rst = r;
        e.exp_flt = f;
        sb.push_back(e);
    endtask

    // monitor: pops expectations between edges and compares with ports
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (rst_out !== e.exp_rst || fault_n !== e.exp_flt) begin
                n_bad++;
                $display("FAIL %s: rst_out=%b fault_n=%b expected rst_out=%b fault_n=%b",
                         e.tag, rst_out, fault_n, e.exp_rst, e.exp_flt);
            end
            if (rst_out_n !== ~e.exp_rst) begin
                n_bad++;
                $display("FAIL R10: rst_out_n=%b expected %b", rst_out_n, ~e.exp_rst);
            end
        end
    end

    initial begin
        fork
            begin
                // reset state
                step(3);
                expect_out("R8 held in reset", 1'b1, 1'b1);
                rst = 1'b0;
                step(PULSE - 1);
                expect_out("R8 pulse after release", 1'b1, 1'b1);
                step(1);
                expect_out("R3 pulse ends", 1'b0, 1'b1);

                // falling kick late in window restarts count
                step(5);
                kick = 1'b0;
                step(12);
                expect_out("R1 window restarted by kick", 1'b0, 1'b1);
                step(1);
                expect_out("R2 time-out", 1'b1, 1'b0);

                // pulse length and periodic pulses with frozen kick
                step(PULSE - 1);
                expect_out("R3 pulse still active", 1'b1, 1'b0);
                step(1);
                expect_out("R5 fault latched after pulse", 1'b0, 1'b0);
                step(WIN - 1);
                expect_out("R4 before second time-out", 1'b0, 1'b0);
                step(1);
                expect_out("R4 periodic pulse", 1'b1, 1'b0);

                // rising kick inside a pulse clears fault, pulse unchanged
                kick = 1'b1;
                step(PULSE);
                expect_out("R5 kick in pulse clears fault", 1'b0, 1'b1);
                step(WIN - 1);
                expect_out("R5 window after pulse", 1'b0, 1'b1);
                step(1);
                expect_out("R2 time-out again", 1'b1, 1'b0);

                // disable
                wd_off = 1'b1;
                step(PULSE);
                expect_out("R7 pulse completes", 1'b0, 1'b0);
                step(40);
                expect_out("R7 no time-out while off", 1'b0, 1'b0);
                wd_off = 1'b0;
                step(WIN - 1);
                expect_out("R7 full window after enable", 1'b0, 1'b0);
                step(1);
                expect_out("R7 time-out after enable", 1'b1, 1'b0);

                // power-good loss
                pwr_ok = 1'b0;
                step(1);
                expect_out("R6 reset and flag high", 1'b1, 1'b1);
                step(30);
                expect_out("R6 held while low", 1'b1, 1'b1);
                pwr_ok = 1'b1;
                step(PULSE - 1);
                expect_out("R6 full pulse on return", 1'b1, 1'b1);
                step(1);
                expect_out("R6 window opens", 1'b0, 1'b1);

                // tick gating
                tick = 1'b0;
                step(50);
                expect_out("R9 frozen without tick", 1'b0, 1'b1);
                tick = 1'b1;
                step(WIN - 1);
                expect_out("R9 count resumes", 1'b0, 1'b1);
                step(1);
                expect_out("R9 time-out after resume", 1'b1, 1'b0);

                // synchronous reset in mid-pulse
                rst = 1'b1;
                step(1);
                expect_out("R8 reset clears fault", 1'b1, 1'b1);
                rst = 1'b0;
                step(PULSE - 1);
                expect_out("R8 full pulse again", 1'b1, 1'b1);
                step(1);
                expect_out("R8 window opens", 1'b0, 1'b1);

                step(2);
            end
            begin
                repeat (5000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: run hung, actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule